// File: doc/BRIEF.md
# Processor clock power-state sequencer

This block follows a processor core through its clock power states and decides when each one is entered and left. It reacts to a halt-instruction strobe, active-low wake, flush, management-interrupt and stop-clock requests, a sleep request, a bus-clock-stopped level and a snoop-activity flag. From the current state it drives a core clock enable, a snoop enable and a ready flag. It also produces one-cycle strobes that tell the bus interface to run a Halt cycle or a Stop Grant Acknowledge cycle.

Leaving the stop, sleep and snoop states is not immediate. A single shared down-counter holds the block in its current state for a fixed number of clocks and then moves it to a target that was latched when the count began. While that count runs, every request is ignored. The block records whether a stop state was reached from Auto Halt, so the stop-clock release can return there without a fresh Halt strobe. Flush service and management-interrupt service end with done pulses from outside. A resume selector decides where the management-interrupt return goes.

Top module: `clk_pwr_seq`

## Requirements
- R1: After synchronous active-high reset, state_o is Normal (code 0), both strobes are low, and core_clk_en_o, snoop_en_o and ready_o are high. State codes are Normal 0, Auto Halt 1, Stop Grant 2, Quick Start 3, Halt/Grant Snoop 4, Sleep 5, Deep Sleep 6, Flush service 7, Interrupt service 8.
- R2: In Normal, halt_i moves the block to Auto Halt on the next clock. halt_cycle_o is high for exactly that first Auto Halt cycle, and core_clk_en_o is low in Auto Halt.
- R3: In Auto Halt, any bit of wake_n_i low returns the block to Normal on the next clock.
- R4: stop_clk_n_i low in Normal or in Auto Halt moves the block to Stop Grant, or to Quick Start when quick_start_i is high. sg_ack_o is high for exactly the first cycle of that state.
- R5: In Stop Grant or Quick Start, stop_clk_n_i high starts a 10-clock exit. The state changes on the 10th clock edge after the one that sampled the release. The target is Auto Halt with no Halt strobe if the stop state was entered from Auto Halt, and Normal otherwise. ready_o is high only in Normal.
- R6: flush_n_i low in Auto Halt enters Flush service (7). flush_done_i then returns the block to Auto Halt on the next clock with no Halt strobe.
- R7: smi_n_i low in Auto Halt enters Interrupt service (8). smi_done_i returns the block to Auto Halt when smi_resume_halt_i is high and to Normal when it is low, with no Halt strobe.
- R8: In Quick Start, snoop_active_i high enters Halt/Grant Snoop on the next clock. After snoop_active_i falls, the block returns to Quick Start on the 3rd edge after the one that sampled the fall.
- R9: snoop_en_o is low in Sleep and Deep Sleep and high in every other state. core_clk_en_o is high only in Normal, Flush service and Interrupt service.
- R10: In Stop Grant, sleep_req_i high enters Sleep on the next clock. In Sleep, sleep_req_i low starts a 10-clock exit back to Stop Grant.
- R11: In Sleep, bus_clk_stopped_i high enters Deep Sleep. When it falls, the block returns to Sleep after 30 x REF_MHZ clocks.
- R12: Requests that arrive while an exit count runs have no effect. The block reaches its latched target at the scheduled edge.
- R13: Priorities are fixed. In Auto Halt the order is interrupt, then flush, then wake, then stop-clock. In Normal, stop-clock wins over halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| halt_i | input | 1 | Halt-instruction strobe |
| wake_n_i | input | NUM_WAKE | Active-low break requests |
| flush_n_i | input | 1 | Active-low flush request |
| flush_done_i | input | 1 | Flush service finished |
| smi_n_i | input | 1 | Active-low management interrupt |
| smi_done_i | input | 1 | Interrupt handler finished |
| smi_resume_halt_i | input | 1 | Handler returns to Auto Halt when high |
| stop_clk_n_i | input | 1 | Active-low stop-clock request |
| quick_start_i | input | 1 | Selects Quick Start instead of Stop Grant |
| sleep_req_i | input | 1 | Sleep request |
| bus_clk_stopped_i | input | 1 | Bus clock stopped indication |
| snoop_active_i | input | 1 | Snoop activity on the bus |
| state_o | output | 4 | Current state code |
| core_clk_en_o | output | 1 | Core clock enable |
| halt_cycle_o | output | 1 | One-cycle Halt bus-cycle strobe |
| sg_ack_o | output | 1 | One-cycle Stop Grant Acknowledge strobe |
| snoop_en_o | output | 1 | Snooping allowed |
| ready_o | output | 1 | Core ready (Normal) |

## Verification
Every request is registered once. A transition that has no count is therefore seen one clock after the edge that sampled the input. A timed exit of N clocks is seen N+1 clocks after the input changed. The driver enqueues each expectation with its due cycle computed this way. It also enqueues a check one cycle earlier, so that an exit that lands early is caught. The monitor pops entries on the falling edge of their due cycle and compares the state, both strobes and the derived enables.

// File: rtl/clk_pwr_pkg.sv
package clk_pwr_pkg;

    typedef enum logic [3:0] {
        PS_RUN     = 4'd0,
        PS_HALT    = 4'd1,
        PS_STOPGNT = 4'd2,
        PS_QSTART  = 4'd3,
        PS_SNOOP   = 4'd4,
        PS_SLEEP   = 4'd5,
        PS_DEEP    = 4'd6,
        PS_FLUSH   = 4'd7,
        PS_SMI     = 4'd8
    } pwr_state_e;

    typedef struct packed {
        logic clk_en;
        logic snoop_en;
        logic ready;
    } pwr_ctl_t;

    // Stop state chosen on a stop-clock request
    function automatic pwr_state_e stop_target(input logic quick);
        return quick ? PS_QSTART : PS_STOPGNT;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/cps_exit_timer.sv
module cps_exit_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
    assign last = (cnt_q == W'(1));
endmodule

// File: rtl/cps_ctl_decode.sv
module cps_ctl_decode
    import clk_pwr_pkg::*;
(
    input  pwr_state_e st,
    output pwr_ctl_t   ctl
);
    always_comb begin
        ctl.clk_en   = (st == PS_RUN) || (st == PS_FLUSH) || (st == PS_SMI);
        ctl.snoop_en = !((st == PS_SLEEP) || (st == PS_DEEP));
        ctl.ready    = (st == PS_RUN);
    end
endmodule

// File: rtl/clk_pwr_seq.sv
module clk_pwr_seq
    import clk_pwr_pkg::*;
#(
    parameter int NUM_WAKE   = 5,
    parameter int REF_MHZ    = 33,
    parameter int BUS_EXIT   = 10,
    parameter int SNOOP_TAIL = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                halt_i,
    input  logic [NUM_WAKE-1:0] wake_n_i,
    input  logic                flush_n_i,
    input  logic                flush_done_i,
    input  logic                smi_n_i,
    input  logic                smi_done_i,
    input  logic                smi_resume_halt_i,
    input  logic                stop_clk_n_i,
    input  logic                quick_start_i,
    input  logic                sleep_req_i,
    input  logic                bus_clk_stopped_i,
    input  logic                snoop_active_i,
    output logic [3:0]          state_o,
    output logic                core_clk_en_o,
    output logic                halt_cycle_o,
    output logic                sg_ack_o,
    output logic                snoop_en_o,
    output logic                ready_o
);
    localparam int DEEP_EXIT = 30 * REF_MHZ;
    localparam int CNT_MAX   = int'(max3(DEEP_EXIT, BUS_EXIT, SNOOP_TAIL));
    localparam int CW        = $clog2(CNT_MAX + 1);

    pwr_state_e state_q, state_d;
    pwr_state_e tgt_q, tgt_d;
    logic       from_halt_q, from_halt_d;
    logic       halt_stb_q, halt_stb_d;
    logic       ack_stb_q, ack_stb_d;
    logic       t_load, t_busy, t_last;
    logic [CW-1:0] t_val;
    logic       wake_any;
    pwr_ctl_t   ctl;

    assign wake_any = |(~wake_n_i);

    cps_exit_timer #(.W(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (t_load),
        .load_val(t_val),
        .busy    (t_busy),
        .last    (t_last)
    );

    always_comb begin
        state_d     = state_q;
        tgt_d       = tgt_q;
        from_halt_d = from_halt_q;
        halt_stb_d  = 1'b0;
        ack_stb_d   = 1'b0;
        t_load      = 1'b0;
        t_val       = '0;
        if (t_busy) begin
            // exit count running: hold, ignore requests
            if (t_last) state_d = tgt_q;
        end else begin
            case (state_q)
                PS_RUN: begin
                    if (!stop_clk_n_i) begin
                        state_d     = stop_target(quick_start_i);
                        ack_stb_d   = 1'b1;
                        from_halt_d = 1'b0;
                    end else if (halt_i) begin
                        state_d    = PS_HALT;
                        halt_stb_d = 1'b1;
                    end
                end
                PS_HALT: begin
                    if (!smi_n_i)        state_d = PS_SMI;
                    else if (!flush_n_i) state_d = PS_FLUSH;
                    else if (wake_any)   state_d = PS_RUN;
                    else if (!stop_clk_n_i) begin
                        state_d     = stop_target(quick_start_i);
                        ack_stb_d   = 1'b1;
                        from_halt_d = 1'b1;
                    end
                end
                PS_FLUSH: if (flush_done_i) state_d = PS_HALT;
                PS_SMI: if (smi_done_i) state_d = smi_resume_halt_i ? PS_HALT : PS_RUN;
                PS_STOPGNT: begin
                    if (sleep_req_i) begin
                        state_d = PS_SLEEP;
                    end else if (stop_clk_n_i) begin
                        t_load = 1'b1;
                        t_val  = CW'(BUS_EXIT);
                        tgt_d  = from_halt_q ? PS_HALT : PS_RUN;
                    end
                end
                PS_QSTART: begin
                    if (stop_clk_n_i) begin
                        t_load = 1'b1;
                        t_val  = CW'(BUS_EXIT);
                        tgt_d  = from_halt_q ? PS_HALT : PS_RUN;
                    end else if (snoop_active_i) begin
                        state_d = PS_SNOOP;
                    end
                end
                PS_SNOOP: begin
                    if (!snoop_active_i) begin
                        t_load = 1'b1;
                        t_val  = CW'(SNOOP_TAIL);
                        tgt_d  = PS_QSTART;
                    end
                end
                PS_SLEEP: begin
                    if (!sleep_req_i) begin
                        t_load = 1'b1;
                        t_val  = CW'(BUS_EXIT);
                        tgt_d  = PS_STOPGNT;
                    end else if (bus_clk_stopped_i) begin
                        state_d = PS_DEEP;
                    end
                end
                PS_DEEP: begin
                    if (!bus_clk_stopped_i) begin
                        t_load = 1'b1;
                        t_val  = CW'(DEEP_EXIT);
                        tgt_d  = PS_SLEEP;
                    end
                end
                default: state_d = PS_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= PS_RUN;
            tgt_q       <= PS_RUN;
            from_halt_q <= 1'b0;
            halt_stb_q  <= 1'b0;
            ack_stb_q   <= 1'b0;
        end else begin
            state_q     <= state_d;
            tgt_q       <= tgt_d;
            from_halt_q <= from_halt_d;
            halt_stb_q  <= halt_stb_d;
            ack_stb_q   <= ack_stb_d;
        end
    end

    cps_ctl_decode u_dec (
        .st (state_q),
        .ctl(ctl)
    );

    assign state_o       = state_q;
    assign core_clk_en_o = ctl.clk_en;
    assign snoop_en_o    = ctl.snoop_en;
    assign ready_o       = ctl.ready;
    assign halt_cycle_o  = halt_stb_q;
    assign sg_ack_o      = ack_stb_q;
endmodule

// File: rtl/clk_pwr_seq_chk.sv
module clk_pwr_seq_chk
    import clk_pwr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [3:0] state_o,
    input logic       halt_cycle_o,
    input logic       sg_ack_o,
    input logic       snoop_en_o,
    input logic       core_clk_en_o
);
    assert_halt_entry_R2: assert property (@(posedge clk) disable iff (rst)
        halt_cycle_o |-> (state_o == PS_HALT && $past(state_o) == PS_RUN));

    assert_halt_single_R2: assert property (@(posedge clk) disable iff (rst)
        halt_cycle_o |=> !halt_cycle_o);

    assert_ack_entry_R4: assert property (@(posedge clk) disable iff (rst)
        sg_ack_o |-> ((state_o == PS_STOPGNT || state_o == PS_QSTART) &&
                      ($past(state_o) == PS_RUN || $past(state_o) == PS_HALT)));

    assert_no_snoop_asleep_R9: assert property (@(posedge clk) disable iff (rst)
        (state_o == PS_SLEEP || state_o == PS_DEEP) |-> (!snoop_en_o && !core_clk_en_o));

    assert_snoop_return_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(state_o) == PS_SNOOP && state_o != PS_SNOOP) |-> state_o == PS_QSTART);

    assert_deep_exit_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(state_o) == PS_DEEP && state_o != PS_DEEP) |-> state_o == PS_SLEEP);

    assert_sleep_entry_R10: assert property (@(posedge clk) disable iff (rst)
        (state_o == PS_SLEEP && $past(state_o) != PS_SLEEP) |->
        ($past(state_o) == PS_STOPGNT || $past(state_o) == PS_DEEP));
endmodule

bind clk_pwr_seq clk_pwr_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .state_o      (state_o),
    .halt_cycle_o (halt_cycle_o),
    .sg_ack_o     (sg_ack_o),
    .snoop_en_o   (snoop_en_o),
    .core_clk_en_o(core_clk_en_o)
);

// File: tb/clk_pwr_seq_bench.sv
module clk_pwr_seq_bench;
    import clk_pwr_pkg::*;

    localparam int NW    = 5;
    localparam int RMHZ  = 2;
    localparam int DEEPX = 30 * RMHZ;
    localparam int BUSX  = 10;
    localparam int TAIL  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic halt_i = 0, flush_n_i = 1, flush_done_i = 0, smi_n_i = 1, smi_done_i = 0;
    logic smi_resume_halt_i = 0, stop_clk_n_i = 1, quick_start_i = 0, sleep_req_i = 0;
    logic bus_clk_stopped_i = 0, snoop_active_i = 0;
    logic [NW-1:0] wake_n_i = '1;
    logic [3:0] state_o;
    logic core_clk_en_o, halt_cycle_o, sg_ack_o, snoop_en_o, ready_o;

    always #10 clk = ~clk;

    clk_pwr_seq #(.NUM_WAKE(NW), .REF_MHZ(RMHZ), .BUS_EXIT(BUSX), .SNOOP_TAIL(TAIL)) u_clk_pwr_seq (
        .clk(clk), .rst(rst), .halt_i(halt_i), .wake_n_i(wake_n_i),
        .flush_n_i(flush_n_i), .flush_done_i(flush_done_i), .smi_n_i(smi_n_i),
        .smi_done_i(smi_done_i), .smi_resume_halt_i(smi_resume_halt_i),
        .stop_clk_n_i(stop_clk_n_i), .quick_start_i(quick_start_i),
        .sleep_req_i(sleep_req_i), .bus_clk_stopped_i(bus_clk_stopped_i),
        .snoop_active_i(snoop_active_i), .state_o(state_o),
        .core_clk_en_o(core_clk_en_o), .halt_cycle_o(halt_cycle_o),
        .sg_ack_o(sg_ack_o), .snoop_en_o(snoop_en_o), .ready_o(ready_o)
    );

    typedef struct {
        int         due;
        logic [3:0] st;
        bit         h;
        bit         s;
        string      tag;
    } exp_t;

    exp_t q[$];
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always @(posedge clk) cyc++;

    task automatic expect_st(input int d, input logic [3:0] st, input bit h, input bit s,
                             input string tag);
        exp_t e;
        e.due = cyc + d; e.st = st; e.h = h; e.s = s; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expectations due this cycle
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].due == cyc) begin
                    logic [7:0] act, expv;
                    logic ce, se, rd;
                    // R9 derived enables, R5 ready only in Normal
                    ce = (q[i].st == 4'd0) || (q[i].st == 4'd7) || (q[i].st == 4'd8);
                    se = !((q[i].st == 4'd5) || (q[i].st == 4'd6));
                    rd = (q[i].st == 4'd0);
                    act  = {state_o, halt_cycle_o, sg_ack_o, core_clk_en_o & snoop_en_o, ready_o};
                    expv = {q[i].st, q[i].h, q[i].s, ce & se, rd};
                    n_chk++;
                    if (act !== expv || core_clk_en_o !== ce || snoop_en_o !== se) begin
                        n_fail++;
                        $display("FAIL %s cyc %0d: actual st=%0d h=%b s=%b ce=%b se=%b rdy=%b expected st=%0d h=%b s=%b ce=%b se=%b rdy=%b",
                                 q[i].tag, cyc, state_o, halt_cycle_o, sg_ack_o, core_clk_en_o,
                                 snoop_en_o, ready_o, q[i].st, q[i].h, q[i].s, ce, se, rd);
                    end
                    q.delete(i);
                end
            end
        end
    end

    initial begin
        step(4);
        rst = 0;
        expect_st(1, 4'd0, 0, 0, "R1");
        step(2);

        // R2 halt entry and single strobe
        halt_i = 1;
        expect_st(1, 4'd1, 1, 0, "R2");
        expect_st(2, 4'd1, 0, 0, "R2");
        step(1); halt_i = 0; step(2);

        // R3 wake
        wake_n_i[1] = 0;
        expect_st(1, 4'd0, 0, 0, "R3");
        step(1); wake_n_i = '1; step(1);

        // R4 stop grant from Auto Halt, R5 timed return without Halt strobe, R12 ignore
        halt_i = 1; step(1); halt_i = 0; step(1);
        stop_clk_n_i = 0;
        expect_st(1, 4'd2, 0, 1, "R4");
        expect_st(2, 4'd2, 0, 0, "R4");
        step(2);
        stop_clk_n_i = 1;
        expect_st(BUSX, 4'd2, 0, 0, "R5");
        expect_st(BUSX + 1, 4'd1, 0, 0, "R5");
        step(4); sleep_req_i = 1; step(2); sleep_req_i = 0;
        expect_st(3, 4'd2, 0, 0, "R12");
        step(BUSX);

        // R4 Quick Start, R8 snoop, R5 exit
        quick_start_i = 1; stop_clk_n_i = 0;
        expect_st(1, 4'd3, 0, 1, "R4");
        step(2);
        snoop_active_i = 1;
        expect_st(1, 4'd4, 0, 0, "R8");
        step(2);
        snoop_active_i = 0;
        expect_st(TAIL, 4'd4, 0, 0, "R8");
        expect_st(TAIL + 1, 4'd3, 0, 0, "R8");
        step(TAIL + 2);
        stop_clk_n_i = 1;
        expect_st(BUSX, 4'd3, 0, 0, "R5");
        expect_st(BUSX + 1, 4'd1, 0, 0, "R5");
        step(BUSX + 2); quick_start_i = 0;

        // R6 flush
        flush_n_i = 0;
        expect_st(1, 4'd7, 0, 0, "R6");
        step(1); flush_n_i = 1; step(2);
        flush_done_i = 1;
        expect_st(1, 4'd1, 0, 0, "R6");
        step(1); flush_done_i = 0; step(1);

        // R7 interrupt, resume to Auto Halt
        smi_n_i = 0;
        expect_st(1, 4'd8, 0, 0, "R7");
        step(1); smi_n_i = 1; step(1);
        smi_resume_halt_i = 1; smi_done_i = 1;
        expect_st(1, 4'd1, 0, 0, "R7");
        step(1); smi_done_i = 0; smi_resume_halt_i = 0; step(1);

        // R13 Auto Halt priority: interrupt wins over all
        smi_n_i = 0; flush_n_i = 0; wake_n_i[0] = 0; stop_clk_n_i = 0;
        expect_st(1, 4'd8, 0, 0, "R13");
        step(1); smi_n_i = 1; flush_n_i = 1; wake_n_i = '1; stop_clk_n_i = 1; step(1);
        smi_done_i = 1;
        expect_st(1, 4'd0, 0, 0, "R7");
        step(1); smi_done_i = 0; step(1);

        // R13 Normal priority: stop-clock over halt
        stop_clk_n_i = 0; halt_i = 1;
        expect_st(1, 4'd2, 0, 1, "R13");
        step(1); halt_i = 0; step(1);

        // R10 sleep, R11 deep sleep
        sleep_req_i = 1;
        expect_st(1, 4'd5, 0, 0, "R10");
        step(2);
        bus_clk_stopped_i = 1;
        expect_st(1, 4'd6, 0, 0, "R11");
        step(2);
        bus_clk_stopped_i = 0;
        expect_st(DEEPX, 4'd6, 0, 0, "R11");
        expect_st(DEEPX + 1, 4'd5, 0, 0, "R11");
        step(DEEPX + 2);
        sleep_req_i = 0;
        expect_st(BUSX, 4'd5, 0, 0, "R10");
        expect_st(BUSX + 1, 4'd2, 0, 0, "R10");
        step(BUSX + 2);

        // R5 exit to Normal when entered from Normal
        stop_clk_n_i = 1;
        expect_st(BUSX, 4'd2, 0, 0, "R5");
        expect_st(BUSX + 1, 4'd0, 0, 0, "R5");
        step(BUSX + 3);

        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R12: actual %0d pending checks, expected 0", q.size());
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule